// File: doc/BRIEF.md
# Post-Trigger Conversion Stop Controller

This block gates an ADC conversion stream. Conversions run first, then a later external trigger arms a counter, and the block shuts the stream off by itself after a programmed number of further conversions. While this mode is active, the external pin is the only trigger source. Software gating and level gating are not used.

The count register is 16 bits wide. It takes the two's-complement negative of the wanted number of conversions and counts up toward zero. A load of 0xFFFF gives one conversion and a load of 0x0000 gives 65,536 conversions. The start of conversions depends on the external-trigger-enable bit. When the bit is 0, conversions begin once the conversion enable is set. When the bit is 1, conversions begin at the first trigger. Clearing the conversion enable stops everything and returns the block to its unprimed state.

Top module: `post_trig_stop`

## Requirements
- R1: After reset, conv_gate_o and done_o are both 0.
- R2: With ext_trig_en_i = 0, conv_gate_o becomes 1 on the first clock edge that samples conv_en_i = 1 with the block unprimed. No trigger is needed.
- R3: With ext_trig_en_i = 1, conv_gate_o stays 0 after conv_en_i is set. It becomes 1 on the clock edge that samples the first trig_i pulse.
- R4: While conversions run and the block is not armed, a trig_i pulse arms the block and captures load_val_i. conv_done_i strobes before arming are not counted. A strobe in the same cycle as the arming trigger is not counted either.
- R5: After arming, each conv_done_i strobe adds one to the count. conv_gate_o drops on the edge that samples the strobe taking the count to zero. The total number of counted strobes is (65536 - load) mod 65536, where a load of 0 gives 65536.
- R6: A load of 0xFFFF gives exactly one counted conversion.
- R7: A load of 0x0000 gives exactly 65,536 counted conversions.
- R8: trig_i pulses after arming do not reload, restart or stop the count.
- R9: done_o rises on the same edge on which conv_gate_o drops at the end of the count. It stays 1 as long as conv_en_i stays 1, and conv_gate_o stays 0 during that time.
- R10: A clock edge that samples conv_en_i = 0 sets conv_gate_o and done_o to 0 and discards any armed count. A later enable then behaves like the first enable after reset.
- R11: trig_i and conv_done_i have no effect while conv_en_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_en_i | input | 1 | Conversion enable; 0 halts the block and re-primes it |
| ext_trig_en_i | input | 1 | 1: the first trigger starts conversions |
| trig_i | input | 1 | Synchronized trigger edge pulse, one cycle wide |
| conv_done_i | input | 1 | Conversion-complete strobe |
| load_val_i | input | 16 | Negated post-trigger count, captured when the block is armed |
| conv_gate_o | output | 1 | Conversions allowed |
| done_o | output | 1 | Count exhausted; sticky until the enable is cleared |

## Verification
The bench measures the exact number of strobes the gate lets through for several load values, including 0xFFFF and 0x0000. An off-by-one in the wrap detection would show up as one conversion too many or too few, and a design that treats 0 as an empty count would stop at once. The bench also sends strobes before arming, a strobe in the same cycle as the arming trigger, and a trigger in the middle of the count. A design that counted early strobes would stop early, and a design that reloaded on a late trigger would run too long. It also clears the enable in the middle of the count and then re-enables with the external trigger set. A design that kept a stale state would raise the gate with no trigger or would show a leftover done flag.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_ARMED = 3'd3,
    ST_STOP  = 3'd4
  } pts_state_e;
endpackage

// File: rtl/pts_counter.sv
module pts_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // strobe that wraps the count to zero
  assign last_o = inc_i && (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/pts_seq.sv
module pts_seq
  import pts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_en_i,
  input  logic ext_trig_en_i,
  input  logic trig_i,
  input  logic conv_done_i,
  input  logic last_i,
  output logic load_o,
  output logic inc_o,
  output logic gate_o,
  output logic done_o
);
  pts_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!conv_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ext_trig_en_i ? ST_WAIT : ST_RUN;
        ST_WAIT:  if (trig_i) state_d = ST_RUN;
        ST_RUN:   if (trig_i) state_d = ST_ARMED;
        ST_ARMED: if (last_i) state_d = ST_STOP;
        ST_STOP:  state_d = ST_STOP;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign load_o = conv_en_i && (state_q == ST_RUN) && trig_i;
  assign inc_o  = conv_en_i && (state_q == ST_ARMED) && conv_done_i;
  assign gate_o = (state_q == ST_RUN) || (state_q == ST_ARMED);
  assign done_o = (state_q == ST_STOP);
endmodule

// File: rtl/post_trig_stop.sv
module post_trig_stop #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_en_i,
  input  logic             ext_trig_en_i,
  input  logic             trig_i,
  input  logic             conv_done_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             conv_gate_o,
  output logic             done_o
);
  logic load, inc, last;

  pts_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .conv_en_i     (conv_en_i),
    .ext_trig_en_i (ext_trig_en_i),
    .trig_i        (trig_i),
    .conv_done_i   (conv_done_i),
    .last_i        (last),
    .load_o        (load),
    .inc_o         (inc),
    .gate_o        (conv_gate_o),
    .done_o        (done_o)
  );

  pts_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val_i),
    .inc_i      (inc),
    .last_o     (last)
  );
endmodule

// File: rtl/post_trig_stop_chk.sv
module post_trig_stop_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_en_i,
  input logic conv_done_i,
  input logic conv_gate_o,
  input logic done_o
);
  a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_en_i |=> (!conv_gate_o && !done_o));

  a_r9_done_no_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !conv_gate_o);

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && conv_en_i) |=> done_o);

  a_r5_done_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(conv_done_i) && $past(conv_gate_o)));

  a_r2_gate_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_gate_o) |-> $past(conv_en_i));

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!conv_gate_o && !done_o));
endmodule

bind post_trig_stop post_trig_stop_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_en_i   (conv_en_i),
  .conv_done_i (conv_done_i),
  .conv_gate_o (conv_gate_o),
  .done_o      (done_o)
);

// File: tb/sim_post_trig_stop.sv
module sim_post_trig_stop;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;
  // {ext_trig_en, load value, expected counted conversions}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 16'hFFFF, 32'd1},
    {1'b1, 16'hFFFE, 32'd2},
    {1'b0, 16'hFFF0, 32'd16},
    {1'b1, 16'hFF00, 32'd256},
    {1'b0, 16'hFFFD, 32'd3},
    {1'b1, 16'hFC18, 32'd1000}
  };

  logic clk = 0, rst_n = 0;
  logic conv_en = 0, ext_en = 0, trig = 0, cdone = 0;
  logic [15:0] load_val = 0;
  logic gate, done;
  int checks = 0, errors = 0;

  post_trig_stop u0 (
    .clk_i(clk), .rst_ni(rst_n), .conv_en_i(conv_en), .ext_trig_en_i(ext_en),
    .trig_i(trig), .conv_done_i(cdone), .load_val_i(load_val),
    .conv_gate_o(gate), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_trig();
    trig = 1; tick(); trig = 0;
  endtask

  // enable and start conversions according to ext
  task automatic start(logic ext);
    ext_en = ext; conv_en = 1; tick();
    if (ext) begin
      check("R3 gate waits for trigger", gate, 0);
      tick();
      check("R3 gate still low", gate, 0);
      pulse_trig();
    end
    check(ext ? "R3 gate after first trigger" : "R2 gate on enable", gate, 1);
  endtask

  // strobe every cycle until the gate falls; return counted strobes
  task automatic count_conv(output int n);
    n = 0;
    cdone = 1;
    for (int i = 0; i < 70000; i++) begin
      tick(); n++;
      if (!gate) break;
    end
    cdone = 0;
  endtask

  task automatic stop();
    conv_en = 0; tick();
    check("R10 gate cleared", gate, 0);
    check("R10 done cleared", done, 0);
  endtask

  initial begin
    int n;
    tick();
    check("R1 gate at reset", gate, 0);
    check("R1 done at reset", done, 0);
    rst_n = 1; tick();

    // R11: activity with enable low
    trig = 1; cdone = 1; tick(); tick(); trig = 0; cdone = 0; tick();
    check("R11 gate idle", gate, 0);
    check("R11 done idle", done, 0);

    for (int v = 0; v < NVEC; v++) begin
      start(VEC[v][48]);
      // R4: strobes before arming do not count
      cdone = 1; tick(); tick(); cdone = 0;
      load_val = VEC[v][47:32];
      pulse_trig();
      count_conv(n);
      check("R5 conversion count", n, VEC[v][31:0]);
      check("R9 done raised", done, 1);
      tick(); tick();
      check("R9 done sticky", done, 1);
      check("R9 gate stays low", gate, 0);
      stop();
    end

    // R4: strobe coincident with arming trigger not counted
    start(0);
    load_val = 16'hFFFE;
    trig = 1; cdone = 1; tick(); trig = 0; cdone = 0;
    check("R4 gate after coincident strobe", gate, 1);
    count_conv(n);
    check("R4 coincident strobe not counted", n, 2);
    stop();

    // R8: trigger mid-count ignored
    start(0);
    load_val = 16'hFFF6; pulse_trig();
    cdone = 1; tick(); tick(); tick();
    load_val = 16'hFFFF; trig = 1; tick(); trig = 0;
    check("R8 gate after late trigger", gate, 1);
    load_val = 16'h0000;
    count_conv(n);
    check("R8 remaining count", n, 6);
    stop();

    // R6
    start(1);
    load_val = 16'hFFFF; pulse_trig();
    count_conv(n);
    check("R6 single conversion", n, 1);
    stop();

    // R10: abort mid-count, then fresh start with external trigger
    start(0);
    load_val = 16'hFFF0; pulse_trig();
    cdone = 1; tick(); tick(); cdone = 0;
    stop();
    start(1);
    check("R10 no stale done", done, 0);
    load_val = 16'hFFFC; pulse_trig();
    count_conv(n);
    check("R10 fresh count after abort", n, 4);
    stop();

    // R7
    start(0);
    load_val = 16'h0000; pulse_trig();
    count_conv(n);
    check("R7 full count", n, 65536);
    check("R7 done", done, 1);
    stop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule